// File: doc/BRIEF.md
# Second-Level Cache Processor Transaction Responder

This block decides how a second-level cache reacts to each transaction that the processor places on its bus. For each transaction it receives a 5-bit transfer type, three active-low strobes (burst, cache-inhibit, write-through), the tag lookup result and an address-retry input. One clock later it issues exactly one action, or no action. The actions are:

- start a line fill;
- claim the transaction (claim plus address and transfer acknowledge);
- update the cached line;
- invalidate the line;
- push the line out, which means retry the processor, request the bus and copy the dirty line back.

Together with the action it issues a tag write that gives the new valid and dirty bits.

The block also keeps a record of the most recent snoop that the cache observed: read or write, hit or miss. A cacheable burst write that comes directly after a snoop is handled differently, depending on that record. The tag RAM, the data RAM and the bus arbiter sit outside the block. Their roles are represented by the lookup input and by the action and tag-write outputs.

The transfer type is written most significant bit first as `ttype[4:0]`. An `X` in a code means the bit is not examined. The lookup encoding is `2'b00` for a miss, `2'b01` for a clean hit and `2'b11` for a dirty hit. The value `2'b10` is treated as a miss.

Top module: `l2_xact_resp`

## Requirements
- R1: A cacheable burst read (ttype X1X10, burst low, inhibit high) that misses gives fill with tag write valid=1 dirty=0. If it hits (clean or dirty), it gives claim with no tag write.
- R2: A cacheable burst read that hits while address-retry is low in the request cycle gives no action and no tag write.
- R3: A cache-inhibited access (inhibit low, ttype X1010 or X0010) has two outcomes. On a clean hit it gives inval with tag write valid=0 dirty=0. On a dirty hit it gives push with tag write valid=0 dirty=0.
- R4: A write-through write (write-through low, inhibit high, ttype 00X10) has two outcomes on a hit. On a clean hit it gives update with valid=1 dirty=0. On a dirty hit with the burst strobe high (single beat) it gives push with valid=1 dirty=0.
- R5: A cacheable burst write (ttype 00110, burst low, write-through and inhibit high) with no snoop record behaves by lookup result. A dirty hit gives update with valid=1 dirty=0. A clean hit gives claim with valid=1 dirty=1. A miss gives fill with valid=1 dirty=1.
- R6: If that burst write follows a snoop write hit and itself hits, it gives inval with valid=0 dirty=0. If it follows any snoop write and misses, it gives no action.
- R7: If that burst write follows a snoop read hit and hits a clean line, it gives update with valid=1 dirty=0. If it follows a snoop read miss and misses, it gives fill with valid=1 dirty=1.
- R8: A snoop record affects only the next processor transaction. Any processor transaction clears the record.
- R9: Address-only flush (00100) has two outcomes. A clean hit gives inval with valid=0 dirty=0. A dirty hit gives push with valid=0 dirty=0.
- R10: Address-only clean (00000) has two outcomes. A clean hit gives no action. A dirty hit gives push with valid=1 dirty=0.
- R11: Address-only kill (01100) gives inval with valid=0 dirty=0 on any hit and never gives push.
- R12: The outputs come out of reset at zero. A response appears exactly one cycle after a request. At most one action is active in that response. With no response, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Processor transaction with a valid lookup result this cycle |
| ttype | input | 5 | Transfer type, MSB first |
| burst_n | input | 1 | Burst strobe, active low |
| inhibit_n | input | 1 | Cache-inhibit strobe, active low |
| wthru_n | input | 1 | Write-through strobe, active low |
| lookup | input | 2 | Tag result: 00 miss, 01 clean hit, 11 dirty hit |
| retry_n | input | 1 | Address retry seen on the bus, active low |
| snp_valid | input | 1 | A snoop lookup completed this cycle |
| snp_write | input | 1 | That snoop was a write |
| snp_hit | input | 1 | That snoop hit in the cache |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| act_fill | output | 1 | Start a line fill |
| act_claim | output | 1 | Claim, address and transfer acknowledge |
| act_update | output | 1 | Update the cached line |
| act_inval | output | 1 | Invalidate the line |
| act_push | output | 1 | Retry, bus request and copyback |
| tag_we | output | 1 | Write the tag state |
| tag_valid | output | 1 | New valid bit |
| tag_dirty | output | 1 | New dirty bit |

## Verification
The bench targets the places where one transfer type matches several table rows, and the places where history changes the outcome.

- Inhibited read codes also fit the cacheable-read pattern. If inhibit does not take priority, the block claims instead of invalidating.
- A single-beat write-through write to a dirty line must push and not update. Getting this wrong leaves the memory copy stale.
- Burst writes are sent directly after each of the four snoop records. A block that ignores the history allocates after a snoop write miss, or keeps a line the snoop made stale.
- One sequence inserts an unrelated transaction between the snoop and the burst write. This exposes a record that never clears.
- A read hit under retry must come out silent. A block that ignores retry acknowledges a transaction that the bus has cancelled.

// File: rtl/l2r_pkg.sv
package l2r_pkg;

    localparam int TT_W = 5;

    // Tag lookup result encoding; bit 0 marks a hit
    typedef enum logic [1:0] {
        LK_MISS  = 2'b00,
        LK_CLEAN = 2'b01,
        LK_RSVD  = 2'b10,
        LK_DIRTY = 2'b11
    } lookup_e;

    // Transaction classes after decode
    typedef enum logic [2:0] {
        XC_OTHER,
        XC_RD_BURST,
        XC_CI_ACCESS,
        XC_WT_WRITE,
        XC_BURST_WR,
        XC_FLUSH,
        XC_CLEAN,
        XC_KILL
    } xclass_e;

    // Most recent snoop outcome
    typedef enum logic [2:0] {
        SH_NONE,
        SH_RD_HIT,
        SH_RD_MISS,
        SH_WR_HIT,
        SH_WR_MISS
    } shist_e;

    // One response: action strobes plus the tag write
    typedef struct packed {
        logic fill;
        logic claim;
        logic update;
        logic inval;
        logic push;
        logic tag_we;
        logic tag_v;
        logic tag_d;
    } resp_t;

endpackage

// File: rtl/l2r_decode.sv
// l2r_decode: sorts a processor transaction into one class.
// Assumes the strobes are active low. Address-only codes are tested
// first, then inhibited accesses, which take priority over cacheable
// reads and writes.
module l2r_decode
    import l2r_pkg::*;
#(
    parameter int TT_BITS = TT_W
) (
    input  logic [TT_BITS-1:0] ttype,
    input  logic               burst_n,
    input  logic               inhibit_n,
    input  logic               wthru_n,
    output xclass_e            cls
);

    localparam logic [TT_BITS-1:0] CODE_FLUSH = TT_BITS'(5'b00100);
    localparam logic [TT_BITS-1:0] CODE_CLEAN = TT_BITS'(5'b00000);
    localparam logic [TT_BITS-1:0] CODE_KILL  = TT_BITS'(5'b01100);
    localparam logic [TT_BITS-1:0] CODE_BWR   = TT_BITS'(5'b00110);

    logic low_is_10;
    logic ci_code;

    assign low_is_10 = (ttype[1:0] == 2'b10);
    assign ci_code   = (ttype[3:0] == 4'b1010) || (ttype[3:0] == 4'b0010);

    // Classify by priority
    always_comb begin
        cls = XC_OTHER;
        if (ttype == CODE_FLUSH) begin
            cls = XC_FLUSH;
        end else if (ttype == CODE_CLEAN) begin
            cls = XC_CLEAN;
        end else if (ttype == CODE_KILL) begin
            cls = XC_KILL;
        end else if (!inhibit_n && ci_code) begin
            cls = XC_CI_ACCESS;
        end else if (inhibit_n && ttype[3] && low_is_10 && !burst_n) begin
            cls = XC_RD_BURST;
        end else if (inhibit_n && !wthru_n && (ttype[4:3] == 2'b00) && low_is_10) begin
            cls = XC_WT_WRITE;
        end else if (inhibit_n && (ttype == CODE_BWR) && !burst_n) begin
            cls = XC_BURST_WR;
        end
    end

endmodule

// File: rtl/l2r_snoop_hist.sv
// l2r_snoop_hist: holds the outcome of the latest snoop until the next
// processor transaction takes it. Assumes that a snoop and a request in
// the same cycle mean that the request came first, so the new snoop is kept.
module l2r_snoop_hist
    import l2r_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   snp_valid,
    input  logic   snp_write,
    input  logic   snp_hit,
    input  logic   consume,
    output shist_e hist
);

    shist_e snp_code;

    // Encode the incoming snoop outcome
    always_comb begin
        case ({snp_write, snp_hit})
            2'b00:   snp_code = SH_RD_MISS;
            2'b01:   snp_code = SH_RD_HIT;
            2'b10:   snp_code = SH_WR_MISS;
            default: snp_code = SH_WR_HIT;
        endcase
    end

    // Record a snoop, or clear the record once a request has used it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist <= SH_NONE;
        end else if (snp_valid) begin
            hist <= snp_code;
        end else if (consume) begin
            hist <= SH_NONE;
        end
    end

endmodule

// File: rtl/l2r_policy.sv
// l2r_policy: combinational response table. It maps the transaction
// class, lookup result, beat size, retry and snoop record to one action
// and one tag write. Assumes that a lookup of 2'b10 is a miss.
module l2r_policy
    import l2r_pkg::*;
(
    input  xclass_e    cls,
    input  logic [1:0] lookup,
    input  logic       burst_n,
    input  logic       retry_n,
    input  shist_e     hist,
    output resp_t      resp
);

    logic hit;
    logic dirty;
    logic after_wr;

    assign hit      = lookup[0];
    assign dirty    = (lookup == LK_DIRTY);
    assign after_wr = (hist == SH_WR_HIT) || (hist == SH_WR_MISS);

    // Select the action and the new tag state
    always_comb begin
        resp = '0;
        unique case (cls)
            XC_RD_BURST: begin
                if (!hit) begin
                    resp.fill   = 1'b1;
                    resp.tag_we = 1'b1;
                    resp.tag_v  = 1'b1;
                end else if (retry_n) begin
                    resp.claim  = 1'b1;
                end
            end
            XC_CI_ACCESS, XC_FLUSH: begin
                if (hit) begin
                    resp.push   = dirty;
                    resp.inval  = !dirty;
                    resp.tag_we = 1'b1;
                end
            end
            XC_WT_WRITE: begin
                if (hit) begin
                    resp.push   = dirty && burst_n;
                    resp.update = !(dirty && burst_n);
                    resp.tag_we = 1'b1;
                    resp.tag_v  = 1'b1;
                end
            end
            XC_BURST_WR: begin
                if (after_wr && !hit) begin
                    resp = '0;
                end else if ((hist == SH_WR_HIT) && hit) begin
                    resp.inval  = 1'b1;
                    resp.tag_we = 1'b1;
                end else if (!hit) begin
                    resp.fill   = 1'b1;
                    resp.tag_we = 1'b1;
                    resp.tag_v  = 1'b1;
                    resp.tag_d  = 1'b1;
                end else if (dirty || (hist == SH_RD_HIT)) begin
                    resp.update = 1'b1;
                    resp.tag_we = 1'b1;
                    resp.tag_v  = 1'b1;
                end else begin
                    resp.claim  = 1'b1;
                    resp.tag_we = 1'b1;
                    resp.tag_v  = 1'b1;
                    resp.tag_d  = 1'b1;
                end
            end
            XC_CLEAN: begin
                if (dirty) begin
                    resp.push   = 1'b1;
                    resp.tag_we = 1'b1;
                    resp.tag_v  = 1'b1;
                end
            end
            XC_KILL: begin
                if (hit) begin
                    resp.inval  = 1'b1;
                    resp.tag_we = 1'b1;
                end
            end
            default: resp = '0;
        endcase
    end

endmodule

// File: rtl/l2_xact_resp.sv
// l2_xact_resp: top of the second-level cache transaction responder.
// It decodes the request, applies the response table with the snoop
// record, and registers the result, so the response follows one cycle
// after req_valid. Assumes that lookup is valid whenever req_valid is high.
module l2_xact_resp
    import l2r_pkg::*;
#(
    parameter int TT_BITS = TT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [TT_BITS-1:0] ttype,
    input  logic               burst_n,
    input  logic               inhibit_n,
    input  logic               wthru_n,
    input  logic [1:0]         lookup,
    input  logic               retry_n,
    input  logic               snp_valid,
    input  logic               snp_write,
    input  logic               snp_hit,
    output logic               rsp_valid,
    output logic               act_fill,
    output logic               act_claim,
    output logic               act_update,
    output logic               act_inval,
    output logic               act_push,
    output logic               tag_we,
    output logic               tag_valid,
    output logic               tag_dirty
);

    xclass_e cls;
    shist_e  hist;
    resp_t   resp_nxt;
    resp_t   resp_q;

    l2r_decode #(.TT_BITS(TT_BITS)) u_decode (
        .ttype     (ttype),
        .burst_n   (burst_n),
        .inhibit_n (inhibit_n),
        .wthru_n   (wthru_n),
        .cls       (cls)
    );

    l2r_snoop_hist u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .snp_valid (snp_valid),
        .snp_write (snp_write),
        .snp_hit   (snp_hit),
        .consume   (req_valid),
        .hist      (hist)
    );

    l2r_policy u_policy (
        .cls     (cls),
        .lookup  (lookup),
        .burst_n (burst_n),
        .retry_n (retry_n),
        .hist    (hist),
        .resp    (resp_nxt)
    );

    // Register the response one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            resp_q    <= '0;
        end else begin
            rsp_valid <= req_valid;
            resp_q    <= req_valid ? resp_nxt : '0;
        end
    end

    assign act_fill   = resp_q.fill;
    assign act_claim  = resp_q.claim;
    assign act_update = resp_q.update;
    assign act_inval  = resp_q.inval;
    assign act_push   = resp_q.push;
    assign tag_we     = resp_q.tag_we;
    assign tag_valid  = resp_q.tag_v;
    assign tag_dirty  = resp_q.tag_d;

endmodule

// File: rtl/l2_xact_resp_chk.sv
// l2_xact_resp_chk: protocol properties of the responder, checked at
// its ports. It is bound to every instance of l2_xact_resp.
module l2_xact_resp_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic [4:0] ttype,
    input logic       burst_n,
    input logic       inhibit_n,
    input logic [1:0] lookup,
    input logic       retry_n,
    input logic       rsp_valid,
    input logic       act_fill,
    input logic       act_claim,
    input logic       act_update,
    input logic       act_inval,
    input logic       act_push,
    input logic       tag_we,
    input logic       tag_valid,
    input logic       tag_dirty
);

    logic [4:0] acts;
    assign acts = {act_fill, act_claim, act_update, act_inval, act_push};

    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(acts));                                                      // R12
    AST_RESP_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid == $past(req_valid));                                       // R12
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (acts == 5'b0 && !tag_we));                            // R12
    AST_MISS_NO_HIT_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(lookup[0] == 1'b0)) |-> !(act_claim || act_update || act_inval || act_push)); // R1
    AST_RETRY_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(lookup[0] && !retry_n && inhibit_n && !burst_n && ttype[3]
                            && ttype[1:0] == 2'b10)) |-> (acts == 5'b0 && !tag_we)); // R2
    AST_PUSH_CLEARS_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        act_push |-> (tag_we && !tag_dirty));                                 // R3
    AST_KILL_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(ttype == 5'b01100)) |-> (!act_push && !tag_valid)); // R11
    AST_FILL_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        act_fill |-> (tag_we && tag_valid));                                  // R5

endmodule

bind l2_xact_resp l2_xact_resp_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .ttype      (ttype),
    .burst_n    (burst_n),
    .inhibit_n  (inhibit_n),
    .lookup     (lookup),
    .retry_n    (retry_n),
    .rsp_valid  (rsp_valid),
    .act_fill   (act_fill),
    .act_claim  (act_claim),
    .act_update (act_update),
    .act_inval  (act_inval),
    .act_push   (act_push),
    .tag_we     (tag_we),
    .tag_valid  (tag_valid),
    .tag_dirty  (tag_dirty)
);

// File: tb/l2_xact_resp_test.sv
module l2_xact_resp_test;

    // Expected-response bit order: {fill, claim, update, inval, push, tag_we, tag_v, tag_d}
    localparam logic [7:0] E_NONE  = 8'b00000_000;
    localparam logic [7:0] E_FILLC = 8'b10000_110;
    localparam logic [7:0] E_FILLD = 8'b10000_111;
    localparam logic [7:0] E_CLAIM = 8'b01000_000;
    localparam logic [7:0] E_CLMD  = 8'b01000_111;
    localparam logic [7:0] E_UPD   = 8'b00100_110;
    localparam logic [7:0] E_INV   = 8'b00010_100;
    localparam logic [7:0] E_PUSHI = 8'b00001_100;
    localparam logic [7:0] E_PUSHK = 8'b00001_110;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [4:0] ttype = 5'b0;
    logic       burst_n = 1'b1;
    logic       inhibit_n = 1'b1;
    logic       wthru_n = 1'b1;
    logic [1:0] lookup = 2'b00;
    logic       retry_n = 1'b1;
    logic       snp_valid = 1'b0;
    logic       snp_write = 1'b0;
    logic       snp_hit = 1'b0;
    logic       rsp_valid;
    logic       act_fill, act_claim, act_update, act_inval, act_push;
    logic       tag_we, tag_valid, tag_dirty;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    l2_xact_resp uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .ttype(ttype),
        .burst_n(burst_n), .inhibit_n(inhibit_n), .wthru_n(wthru_n),
        .lookup(lookup), .retry_n(retry_n), .snp_valid(snp_valid),
        .snp_write(snp_write), .snp_hit(snp_hit), .rsp_valid(rsp_valid),
        .act_fill(act_fill), .act_claim(act_claim), .act_update(act_update),
        .act_inval(act_inval), .act_push(act_push), .tag_we(tag_we),
        .tag_valid(tag_valid), .tag_dirty(tag_dirty)
    );

    function automatic logic [7:0] observed();
        return {act_fill, act_claim, act_update, act_inval, act_push, tag_we, tag_valid, tag_dirty};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    // Driver: present one request for a cycle and queue its expected response
    task automatic drive(input string req, input logic [4:0] tt, input logic b, input logic ci,
                         input logic wt, input logic [1:0] lk, input logic rt, input logic [7:0] exp);
        @(negedge clk);
        ttype = tt; burst_n = b; inhibit_n = ci; wthru_n = wt; lookup = lk; retry_n = rt;
        req_valid = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(req);
        @(negedge clk);
        req_valid = 1'b0;
        retry_n = 1'b1;
        @(negedge clk);
    endtask

    // Snoop pulse for one cycle
    task automatic snoop(input logic wr, input logic hit);
        @(negedge clk);
        snp_valid = 1'b1; snp_write = wr; snp_hit = hit;
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    // Monitor: compare every response with the head of the queue
    always @(negedge clk) begin
        if (rst_n) begin
            if (rsp_valid) begin
                if (exp_q.size() == 0) begin
                    check("R12 unexpected response", 8'hFF, 8'h00);
                end else begin
                    logic [7:0] e;
                    string      t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(t, observed(), e);
                    check("R12 one action", 8'($countones(observed()[7:3]) <= 1), 8'd1);
                end
            end else if (observed() != 8'h00) begin
                check("R12 quiet when idle", observed(), 8'h00);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R12 reset state", {rsp_valid, observed()[7:1]}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        drive("R1 burst read miss",       5'b01010, 0, 1, 1, 2'b00, 1, E_FILLC);
        drive("R1 burst read clean hit",  5'b01110, 0, 1, 1, 2'b01, 1, E_CLAIM);
        drive("R1 burst read dirty hit",  5'b11010, 0, 1, 1, 2'b11, 1, E_CLAIM);
        drive("R2 read hit under retry",  5'b01010, 0, 1, 1, 2'b01, 0, E_NONE);
        drive("R3 inhibited read clean",  5'b01010, 0, 0, 1, 2'b01, 1, E_INV);
        drive("R3 inhibited read dirty",  5'b11010, 1, 0, 1, 2'b11, 1, E_PUSHI);
        drive("R3 inhibited write dirty", 5'b00010, 1, 0, 1, 2'b11, 1, E_PUSHI);
        drive("R4 wt write clean",        5'b00010, 1, 1, 0, 2'b01, 1, E_UPD);
        drive("R4 wt single write dirty", 5'b00010, 1, 1, 0, 2'b11, 1, E_PUSHK);
        drive("R5 burst write dirty",     5'b00110, 0, 1, 1, 2'b11, 1, E_UPD);
        drive("R5 burst write clean",     5'b00110, 0, 1, 1, 2'b01, 1, E_CLMD);
        drive("R5 burst write miss",      5'b00110, 0, 1, 1, 2'b00, 1, E_FILLD);

        snoop(1, 1);
        drive("R6 after snoop write hit",  5'b00110, 0, 1, 1, 2'b01, 1, E_INV);
        snoop(1, 0);
        drive("R6 after snoop write miss", 5'b00110, 0, 1, 1, 2'b00, 1, E_NONE);
        snoop(0, 1);
        drive("R7 after snoop read hit",   5'b00110, 0, 1, 1, 2'b01, 1, E_UPD);
        snoop(0, 0);
        drive("R7 after snoop read miss",  5'b00110, 0, 1, 1, 2'b00, 1, E_FILLD);

        snoop(1, 1);
        drive("R8 intervening read",       5'b01010, 0, 1, 1, 2'b00, 1, E_FILLC);
        drive("R8 record consumed",        5'b00110, 0, 1, 1, 2'b01, 1, E_CLMD);

        drive("R9 flush clean",  5'b00100, 1, 1, 1, 2'b01, 1, E_INV);
        drive("R9 flush dirty",  5'b00100, 1, 1, 1, 2'b11, 1, E_PUSHI);
        drive("R9 flush miss",   5'b00100, 1, 1, 1, 2'b00, 1, E_NONE);
        drive("R10 clean clean", 5'b00000, 1, 1, 1, 2'b01, 1, E_NONE);
        drive("R10 clean dirty", 5'b00000, 1, 1, 1, 2'b11, 1, E_PUSHK);
        drive("R11 kill dirty",  5'b01100, 1, 1, 1, 2'b11, 1, E_INV);
        drive("R11 kill clean",  5'b01100, 1, 1, 1, 2'b01, 1, E_INV);

        repeat (3) @(negedge clk);
        check("R12 all responses seen", 8'(exp_q.size()), 8'd0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule